// File: doc/BRIEF.md
# Legacy Interrupt Latch and FPU-Error Logic

This block sits in a south-bridge style controller. It holds one 32-bit general control register that is read and written over a simple configuration-register bus. The enable bits in that register drive three pieces of legacy interrupt logic: a keyboard interrupt latch, a mouse interrupt latch, and the generator for the floating-point error interrupt. The register also exports two plain control bits to neighbouring logic, and one break-event indication.

The raw IRQ1, IRQ12 and active-low FERR# inputs first pass through two synchroniser flops. Each interrupt latch is a two-state machine. In `LAT_IDLE`, a rising edge seen while the latch is enabled moves it to `LAT_HELD` (transition *capture*). A read of I/O port 60h moves it back (transition *release*), and so does clearing the enable bit (transition *disarm*). While its enable bit is clear, the channel is a plain pass-through of the synchronised level.

The FPU-error machine also has two states. In `FE_IDLE`, FERR# seen low while enabled moves it to `FE_RAISED` (transition *raise*). A write to I/O port F0h moves it back (transition *ack*), and so does clearing the enable bit (transition *disarm*). While in `FE_RAISED` it drives IRQ13 high and IGNNE# low.

Top module: `legacy_irq_ctl`

## Requirements
- R1: After reset the control register reads 00000000h at dword index 34h (byte offset D0h), IRQ1/IRQ12/IRQ13 are low, IGNNE# is high. Reads at any other dword index return zero.
- R2: Only bits 25, 24, 21, 17:14, 13, 12 and 11 are writable (mask 0323F800h). All other bits read zero whatever is written.
- R3: A write updates only the byte lanes whose byte enable is set (cfg_be[n] selects bits 8n+7:8n).
- R4: With bit 12 set, a rising edge on irq1_raw sets irq1_out. It stays high, even after the input falls, until an I/O read (io_write=0) of port 0060h.
- R5: With bit 12 (for IRQ1) or bit 11 (for IRQ12) clear, the output follows its raw input two clock edges after the input changes.
- R6: With bit 11 set, irq12_out behaves as in R4, driven by irq12_raw and cleared by the same port 0060h read.
- R7: If a rising edge and a port 0060h read fall in the same cycle, the latch stays set.
- R8: An I/O write to port 0060h, or a read of any other port, leaves a set latch set.
- R9: With bit 13 set, FERR# low raises irq13_out and drives ignne_n low. Both are held, even after FERR# returns high, until an I/O write (io_write=1) to port 00F0h, which releases both in the same cycle. A read of 00F0h or a write to another port has no effect.
- R10: With bit 13 clear, FERR# raises neither IRQ13 nor IGNNE#.
- R11: brk_evt is high while bit 21 is set and the synchronised FERR# is low.
- R12: hide_bridge mirrors bit 24 and req_proto_sel mirrors bit 25. Bits 17:14 are storage only and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr |
| irq1_raw | input | 1 | Keyboard interrupt, active high, asynchronous |
| irq12_raw | input | 1 | Mouse interrupt, active high, asynchronous |
| ferr_n | input | 1 | Floating-point error, active low, asynchronous |
| io_strobe | input | 1 | One-cycle I/O access strobe |
| io_write | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | 16 | I/O port address |
| irq1_out | output | 1 | Keyboard interrupt to the controller |
| irq12_out | output | 1 | Mouse interrupt to the controller |
| irq13_out | output | 1 | FPU-error interrupt |
| ignne_n | output | 1 | Ignore-numeric-error, active low |
| brk_evt | output | 1 | FERR# break-event indication |
| hide_bridge | output | 1 | Register bit 24 |
| req_proto_sel | output | 1 | Register bit 25 |

## Verification
On every cycle the assertions check the latch machines' capture, hold and release transitions and the edge-over-read priority. They also check the FPU-error raise, hold and disarm transitions, that reserved read bits are zero, and that a write with no byte enables leaves the register unchanged. Only the bench scenarios can show the rest: the exact two-edge latency of the bypass path, which port and direction clears each latch, the per-bit write mask, and the per-lane write sweep. These depend on the decode of particular addresses and on values observed at the ports, not on a single transition.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int CFG_W     = 32;
    localparam int DW_ADDR_W = 6;
    localparam int IO_ADDR_W = 16;
    localparam int LANES     = CFG_W / 8;

    localparam logic [DW_ADDR_W-1:0] CTL_DW = 6'h34;

    localparam int B_PROTO = 25;
    localparam int B_HIDE  = 24;
    localparam int B_BRK   = 21;
    localparam int SCR_LO  = 14;
    localparam int SCR_W   = 4;
    localparam int B_FPU   = 13;
    localparam int B_KBD   = 12;
    localparam int B_MSE   = 11;

    localparam logic [CFG_W-1:0] CTL_WMASK =
        (CFG_W'(1) << B_PROTO) | (CFG_W'(1) << B_HIDE) | (CFG_W'(1) << B_BRK) |
        (((CFG_W'(1) << SCR_W) - CFG_W'(1)) << SCR_LO) |
        (CFG_W'(1) << B_FPU) | (CFG_W'(1) << B_KBD) | (CFG_W'(1) << B_MSE);

    localparam logic [IO_ADDR_W-1:0] PORT_KBD = 16'h0060;
    localparam logic [IO_ADDR_W-1:0] PORT_FPU = 16'h00F0;

    typedef enum logic {LAT_IDLE, LAT_HELD} lat_state_e;
    typedef enum logic {FE_IDLE, FE_RAISED} fe_state_e;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[s] <= RST_VAL;
            end else begin
                stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lic_cfg_reg.sv
module lic_cfg_reg
    import lic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [DW_ADDR_W-1:0] dw_addr_i,
    input  logic [LANES-1:0]     be_i,
    input  logic [CFG_W-1:0]     wdata_i,
    output logic [CFG_W-1:0]     rdata_o,
    output logic                 en_fpu_o,
    output logic                 en_kbd_o,
    output logic                 en_mse_o,
    output logic                 en_brk_o,
    output logic                 hide_o,
    output logic                 proto_o
);
    logic [CFG_W-1:0] ctl_q;
    logic             hit;

    assign hit = (dw_addr_i == CTL_DW);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[ln*8 +: 8] <= '0;
            end else if (wr_i && hit && be_i[ln]) begin
                ctl_q[ln*8 +: 8] <= wdata_i[ln*8 +: 8] & CTL_WMASK[ln*8 +: 8];
            end
        end
    end

    always_comb begin
        rdata_o  = hit ? ctl_q : '0;
        en_fpu_o = ctl_q[B_FPU];
        en_kbd_o = ctl_q[B_KBD];
        en_mse_o = ctl_q[B_MSE];
        en_brk_o = ctl_q[B_BRK];
        hide_o   = ctl_q[B_HIDE];
        proto_o  = ctl_q[B_PROTO];
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_o & ~CTL_WMASK) == '0));

    assert_no_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && be_i == '0) |=> $stable(ctl_q));
endmodule

// File: rtl/lic_irq_latch.sv
module lic_irq_latch
    import lic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_i,
    input  logic clr_i,
    output logic irq_o
);
    lat_state_e st_q, st_d;
    logic       prev_q;
    logic       rise;

    assign rise = lvl_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LAT_IDLE;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            prev_q <= lvl_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LAT_IDLE: if (en_i && rise)      st_d = LAT_HELD;
            LAT_HELD: if (!en_i)             st_d = LAT_IDLE;
                      else if (clr_i && !rise) st_d = LAT_IDLE;
            default:                         st_d = LAT_IDLE;
        endcase
    end

    always_comb begin
        irq_o = en_i ? (st_q == LAT_HELD) : lvl_i;
    end

    // R4 and R6 share this latch
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && irq_o && !clr_i) |=> (irq_o || !en_i));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rise) |=> (irq_o || !en_i));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_i && !rise) |=> (!irq_o || !en_i));

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rise && clr_i) |=> (irq_o || !en_i));
endmodule

// File: rtl/lic_fpu_err.sv
module lic_fpu_err
    import lic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fault_i,
    input  logic clr_i,
    output logic irq13_o,
    output logic ignne_n_o
);
    fe_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FE_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FE_IDLE:   if (en_i && fault_i)  st_d = FE_RAISED;
            FE_RAISED: if (!en_i || clr_i)   st_d = FE_IDLE;
            default:                         st_d = FE_IDLE;
        endcase
    end

    always_comb begin
        irq13_o   = (st_q == FE_RAISED);
        ignne_n_o = (st_q != FE_RAISED);
    end

    assert_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && fault_i && !irq13_o) |=> irq13_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && irq13_o && !clr_i) |=> (irq13_o && !ignne_n_o));

    assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (!irq13_o && ignne_n_o));
endmodule

// File: rtl/legacy_irq_ctl.sv
module legacy_irq_ctl
    import lic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [DW_ADDR_W-1:0] cfg_dw_addr,
    input  logic [LANES-1:0]     cfg_be,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 irq1_raw,
    input  logic                 irq12_raw,
    input  logic                 ferr_n,
    input  logic                 io_strobe,
    input  logic                 io_write,
    input  logic [IO_ADDR_W-1:0] io_addr,
    output logic                 irq1_out,
    output logic                 irq12_out,
    output logic                 irq13_out,
    output logic                 ignne_n,
    output logic                 brk_evt,
    output logic                 hide_bridge,
    output logic                 req_proto_sel
);
    logic       en_fpu, en_kbd, en_mse, en_brk;
    logic [2:0] raw_vec, sync_vec;
    logic       kbd_clr, fpu_clr, fault;

    lic_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr),
        .dw_addr_i (cfg_dw_addr),
        .be_i      (cfg_be),
        .wdata_i   (cfg_wdata),
        .rdata_o   (cfg_rdata),
        .en_fpu_o  (en_fpu),
        .en_kbd_o  (en_kbd),
        .en_mse_o  (en_mse),
        .en_brk_o  (en_brk),
        .hide_o    (hide_bridge),
        .proto_o   (req_proto_sel)
    );

    assign raw_vec = {ferr_n, irq12_raw, irq1_raw};

    lic_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    assign kbd_clr = io_strobe && !io_write && (io_addr == PORT_KBD);
    assign fpu_clr = io_strobe &&  io_write && (io_addr == PORT_FPU);
    assign fault   = ~sync_vec[2];

    lic_irq_latch u_kbd (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_kbd),
        .lvl_i (sync_vec[0]),
        .clr_i (kbd_clr),
        .irq_o (irq1_out)
    );

    lic_irq_latch u_mse (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_mse),
        .lvl_i (sync_vec[1]),
        .clr_i (kbd_clr),
        .irq_o (irq12_out)
    );

    lic_fpu_err u_fpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_fpu),
        .fault_i   (fault),
        .clr_i     (fpu_clr),
        .irq13_o   (irq13_out),
        .ignne_n_o (ignne_n)
    );

    assign brk_evt = en_brk & fault;

    assert_brk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[B_BRK] && cfg_dw_addr == CTL_DW) |-> !brk_evt);
endmodule

// File: tb/legacy_irq_ctl_tb.sv
module legacy_irq_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h0323_F800;
    localparam logic [5:0]  CTL  = 6'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = CTL;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq1_raw = 1'b0, irq12_raw = 1'b0, ferr_n = 1'b1;
    logic        io_strobe = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic        irq1_out, irq12_out, irq13_out, ignne_n, brk_evt;
    logic        hide_bridge, req_proto_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_irq_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq1_raw(irq1_raw), .irq12_raw(irq12_raw), .ferr_n(ferr_n),
        .io_strobe(io_strobe), .io_write(io_write), .io_addr(io_addr),
        .irq1_out(irq1_out), .irq12_out(irq12_out), .irq13_out(irq13_out),
        .ignne_n(ignne_n), .brk_evt(brk_evt), .hide_bridge(hide_bridge),
        .req_proto_sel(req_proto_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_dw_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        cfg_dw_addr = a;
        #1 d = cfg_rdata;
        cfg_dw_addr = CTL;
    endtask

    task automatic io_cycle(input logic wr, input logic [15:0] a);
        io_write = wr; io_addr = a; io_strobe = 1'b1;
        cyc(1);
        io_strobe = 1'b0;
    endtask

    task automatic set_raw(input int ch, input logic v);
        if (ch == 0) irq1_raw = v; else irq12_raw = v;
    endtask

    function automatic logic get_out(input int ch);
        return (ch == 0) ? irq1_out : irq12_out;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] lanes;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        cfg_read(CTL, rd);
        check("R1 reset value", rd, 32'h0);
        check("R1 irq outputs", {29'd0, irq1_out, irq12_out, irq13_out}, 32'h0);
        check("R1 ignne_n high", {31'd0, ignne_n}, 32'h1);

        // R2 per-bit write mask sweep
        for (int b = 0; b < 32; b++) begin
            cfg_write(CTL, 4'hF, 32'h1 << b);
            cfg_read(CTL, rd);
            check($sformatf("R2 bit %0d", b), rd, (32'h1 << b) & MASK);
        end
        cfg_write(CTL, 4'hF, 32'hFFFF_FFFF);
        cfg_read(CTL, rd);
        check("R2 all ones", rd, MASK);
        for (int a = 0; a < 64; a++) begin
            if (a[5:0] != CTL) begin
                cfg_read(a[5:0], rd);
                check("R1 other offset reads zero", rd, 32'h0);
            end
        end

        // R3 byte-enable sweep
        for (int be = 0; be < 16; be++) begin
            cfg_write(CTL, 4'hF, 32'h0);
            cfg_write(CTL, be[3:0], 32'hFFFF_FFFF);
            lanes = '0;
            for (int ln = 0; ln < 4; ln++) if (be[ln]) lanes |= 32'hFF << (8 * ln);
            cfg_read(CTL, rd);
            check($sformatf("R3 be %0h", be), rd, MASK & lanes);
        end
        cfg_write(6'h00, 4'hF, 32'hFFFF_FFFF);
        cfg_read(CTL, rd);
        check("R3 miss offset write ignored", rd, MASK & 32'hFFFF_FFFF & lanes);

        // R12 exported bits, scratch has no effect
        for (int v = 0; v < 4; v++) begin
            cfg_write(CTL, 4'hF, (32'(v) << 24) | (32'hF << 14));
            cyc(1);
            check($sformatf("R12 hide v%0d", v), {31'd0, hide_bridge}, 32'(v & 1));
            check($sformatf("R12 proto v%0d", v), {31'd0, req_proto_sel}, 32'(v >> 1));
            check("R12 scratch no effect", {28'd0, irq1_out, irq12_out, irq13_out, brk_evt}, 32'h0);
        end

        // R11 break event and R10 FERR ignored while bit 13 clear
        cfg_write(CTL, 4'hF, 32'h1 << 21);
        ferr_n = 1'b0;
        cyc(4);
        check("R11 brk on", {31'd0, brk_evt}, 32'h1);
        check("R10 no irq13", {31'd0, irq13_out}, 32'h0);
        check("R10 ignne_n high", {31'd0, ignne_n}, 32'h1);
        ferr_n = 1'b1;
        cyc(4);
        check("R11 brk off after FERR high", {31'd0, brk_evt}, 32'h0);
        cfg_write(CTL, 4'hF, 32'h0);
        ferr_n = 1'b0;
        cyc(4);
        check("R11 brk off when disabled", {31'd0, brk_evt}, 32'h0);
        ferr_n = 1'b1;
        cyc(4);

        // R9 FPU error raise, hold, ack
        cfg_write(CTL, 4'hF, 32'h1 << 13);
        ferr_n = 1'b0;
        cyc(4);
        check("R9 irq13 raised", {31'd0, irq13_out}, 32'h1);
        check("R9 ignne_n low", {31'd0, ignne_n}, 32'h0);
        ferr_n = 1'b1;
        cyc(4);
        check("R9 held after FERR high", {30'd0, irq13_out, ignne_n}, 32'h2);
        io_cycle(1'b0, 16'h00F0);
        check("R9 read F0 no clear", {30'd0, irq13_out, ignne_n}, 32'h2);
        io_cycle(1'b1, 16'h00F1);
        check("R9 write F1 no clear", {30'd0, irq13_out, ignne_n}, 32'h2);
        io_cycle(1'b1, 16'h00F0);
        check("R9 write F0 releases", {30'd0, irq13_out, ignne_n}, 32'h1);

        // R4 / R6 / R8 latch sweep over both channels
        for (int ch = 0; ch < 2; ch++) begin
            string tag;
            tag = (ch == 0) ? "R4" : "R6";
            cfg_write(CTL, 4'hF, (ch == 0) ? (32'h1 << 12) : (32'h1 << 11));
            cyc(1);
            check({tag, " idle"}, {31'd0, get_out(ch)}, 32'h0);
            set_raw(ch, 1'b1);
            cyc(4);
            check({tag, " captured"}, {31'd0, get_out(ch)}, 32'h1);
            set_raw(ch, 1'b0);
            cyc(4);
            check({tag, " held after input low"}, {31'd0, get_out(ch)}, 32'h1);
            io_cycle(1'b1, 16'h0060);
            check("R8 write 60h no clear", {31'd0, get_out(ch)}, 32'h1);
            io_cycle(1'b0, 16'h0064);
            check("R8 read 64h no clear", {31'd0, get_out(ch)}, 32'h1);
            io_cycle(1'b0, 16'h0060);
            check({tag, " read 60h clears"}, {31'd0, get_out(ch)}, 32'h0);
            cyc(3);
            check({tag, " stays clear"}, {31'd0, get_out(ch)}, 32'h0);

            // R7 edge in same cycle as port read
            set_raw(ch, 1'b1);
            cyc(2);
            io_write = 1'b0; io_addr = 16'h0060; io_strobe = 1'b1;
            cyc(1);
            io_strobe = 1'b0;
            check("R7 edge wins", {31'd0, get_out(ch)}, 32'h1);
            io_cycle(1'b0, 16'h0060);
            check("R7 later read clears", {31'd0, get_out(ch)}, 32'h0);
            set_raw(ch, 1'b0);
            cyc(4);
        end

        // R5 bypass timing on both channels
        cfg_write(CTL, 4'hF, 32'h0);
        for (int ch = 0; ch < 2; ch++) begin
            set_raw(ch, 1'b1);
            cyc(1);
            check("R5 not yet after one edge", {31'd0, get_out(ch)}, 32'h0);
            cyc(1);
            check("R5 follows after two edges", {31'd0, get_out(ch)}, 32'h1);
            set_raw(ch, 1'b0);
            cyc(2);
            check("R5 follows low", {31'd0, get_out(ch)}, 32'h0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule